// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Flag

This block sits behind the reference and feedback dividers of a frequency synthesizer. Both dividers deliver one-cycle strobes in the oscillator clock domain, and the block turns the gap between them into pump-drive signals. One three-state output steers an on-chip charge pump. A pair of outputs is provided for an external pump: one is always driven, and the other is an open-drain style pin that is either driven low or released. A polarity input swaps the sense of all error outputs, so the block can serve a VCO with either tuning slope. A forced-release input parks the pump pin. A power-save input releases every pump pin and holds the lock flag high, so the loop filter keeps its voltage.

The phase error is the number of oscillator cycles between a strobe on one input and the matching strobe on the other. When both strobes arrive in the same cycle, the block still emits a short balanced pump burst, so the loop has no dead zone around zero error. A lock flag falls as soon as the error reaches an unlock threshold. It rises again only after a run of consecutive good comparisons. A monitor pin shows either the lock flag or one of the divided frequencies.

The strobe inputs and the control pins are plain level signals with no handshake. The dividers cannot be stalled, so there is no back-pressure. A strobe is acted on in the cycle it is seen.

Top module: `pfd_lock_top`

## Requirements
- R1: With pol_sel=1, a ref_edge that comes d>0 cycles before fb_edge makes pump_oe=1 and pump_lvl=1 for exactly d cycles, starting one cycle after ref_edge. In those cycles ext_a_lvl=0 and ext_b_oe=1.
- R2: With pol_sel=1, an fb_edge that comes d>0 cycles before ref_edge makes pump_oe=1 and pump_lvl=0 for exactly d cycles. In those cycles ext_a_lvl=1 and ext_b_oe=0.
- R3: With pol_sel=0, the cases of R1 and R2 swap: a leading ref_edge gives pump_lvl=0, ext_a_lvl=1 and ext_b_oe=0, and a leading fb_edge gives pump_lvl=1, ext_a_lvl=0 and ext_b_oe=1.
- R4: When both strobes come in the same cycle (zero error), the pump is driven for one cycle in the ref-lead sense and then for one cycle in the fb-lead sense. When no comparison is in progress, pump_oe=0, ext_a_lvl=0 and ext_b_oe=0.
- R5: The lock flag falls on the clock edge at which the error count reaches UNLOCK_CYC (default 8). This can happen before the closing strobe arrives. An error of UNLOCK_CYC-1 cycles leaves the flag unchanged.
- R6: After reset the lock flag is 0. It rises after GOOD_RUN (default 3) consecutive comparisons whose error is at most LOCK_CYC (default 16) and below UNLOCK_CYC. A comparison that fails the unlock test restarts the run.
- R7: With mon_sel=1, mon_out shows ref_edge when pol_sel=1 and fb_edge when pol_sel=0. With mon_sel=0, mon_out shows the lock flag. The monitor path is combinational.
- R8: With zc_n=0, pump_oe=0, while the external pump outputs keep working.
- R9: With ps_n=0, pump_oe, ext_a_oe and ext_b_oe are all 0 and lock is 1. Strobes are ignored and any comparison in progress is dropped. After ps_n returns to 1, the block starts idle with lock still 1.
- R10: A second strobe on the leading input before the closing strobe arrives is ignored. The error keeps counting from the first strobe. If the closing strobe and a new leading strobe come in the same cycle, the comparison closes and a new one starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_edge | input | 1 | One-cycle strobe from the reference divider |
| fb_edge | input | 1 | One-cycle strobe from the feedback divider |
| pol_sel | input | 1 | Error polarity: 1 means ref lead drives the pump high |
| mon_sel | input | 1 | Monitor select: 1 frequency, 0 lock flag |
| zc_n | input | 1 | Low forces the on-chip pump output released |
| ps_n | input | 1 | Low selects power save |
| pump_lvl | output | 1 | On-chip pump drive level |
| pump_oe | output | 1 | On-chip pump drive enable (0 = high impedance) |
| ext_a_lvl | output | 1 | External pump output A level |
| ext_a_oe | output | 1 | External pump output A enable |
| ext_b_lvl | output | 1 | External pump output B level (always low when driven) |
| ext_b_oe | output | 1 | External pump output B enable |
| lock | output | 1 | Lock flag |
| mon_out | output | 1 | Monitor output |

## Verification
Two functions can fire on the same clock edge: the unlock decision and entry into power save. If the error count of a lead reaches UNLOCK_CYC in the cycle where ps_n falls, power save must win, and lock reads 1 in the next cycle and after ps_n rises again. The bench forces this by holding off the closing strobe and lowering ps_n in exactly the eighth cycle of the lead. It also runs a comparison that closes and restarts in one cycle, and judges both cases against the pulse widths and flag levels given in the requirements.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REF    = 3'd1,
    ST_FB     = 3'd2,
    ST_BAL_UP = 3'd3,
    ST_BAL_DN = 3'd4
  } pfd_st_e;
endpackage

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int ERR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             ref_edge,
  input  logic             fb_edge,
  output logic             up,
  output logic             dn,
  output logic             leading,
  output logic [ERR_W-1:0] err_cnt,
  output logic             cmp_done,
  output logic [ERR_W-1:0] cmp_err
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  pfd_st_e          st_q, st_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             done_raw;

  // Next state on a strobe pair when no lead is pending.
  function automatic pfd_st_e from_rest(input logic r, input logic f, input pfd_st_e dflt);
    if (r && f)      return ST_BAL_UP;
    else if (r)      return ST_REF;
    else if (f)      return ST_FB;
    else             return dflt;
  endfunction

  always_comb begin
    st_d     = st_q;
    done_raw = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        st_d     = from_rest(ref_edge, fb_edge, ST_IDLE);
        done_raw = ref_edge & fb_edge;
      end
      ST_BAL_UP: begin
        st_d     = from_rest(ref_edge, fb_edge, ST_BAL_DN);
        done_raw = ref_edge & fb_edge;
      end
      ST_BAL_DN: begin
        st_d     = from_rest(ref_edge, fb_edge, ST_IDLE);
        done_raw = ref_edge & fb_edge;
      end
      ST_REF: if (fb_edge) begin
        done_raw = 1'b1;
        st_d     = ref_edge ? ST_REF : ST_IDLE;
      end
      ST_FB: if (ref_edge) begin
        done_raw = 1'b1;
        st_d     = fb_edge ? ST_FB : ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    err_d = '0;
    if (st_d == ST_REF || st_d == ST_FB) begin
      if (st_d != st_q || done_raw)   err_d = {{(ERR_W-1){1'b0}}, 1'b1};
      else if (err_q != ERR_MAX)      err_d = err_q + 1'b1;
      else                            err_d = err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= '0;
    end else if (hold) begin
      st_q  <= ST_IDLE;
      err_q <= '0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign leading  = (st_q == ST_REF) || (st_q == ST_FB);
  assign up       = (st_q == ST_REF) || (st_q == ST_BAL_UP);
  assign dn       = (st_q == ST_FB)  || (st_q == ST_BAL_DN);
  assign err_cnt  = err_q;
  assign cmp_done = done_raw & ~hold;
  assign cmp_err  = leading ? err_q : '0;

  // R4: the balancing up cycle is always followed by the down cycle
  p_bal_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BAL_UP && !ref_edge && !fb_edge && !hold) |=> dn);

  // R10: a repeated leading strobe keeps the lead alive and the count growing
  p_lead_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REF && ref_edge && !fb_edge && !hold && err_q != ERR_MAX) |=> (up && err_cnt > 1));
endmodule

// File: rtl/lock_detect.sv
module lock_detect #(
  parameter int ERR_W      = 6,
  parameter int UNLOCK_CYC = 8,
  parameter int LOCK_CYC   = 16,
  parameter int GOOD_RUN   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save,
  input  logic             leading,
  input  logic [ERR_W-1:0] err_cnt,
  input  logic             cmp_done,
  input  logic [ERR_W-1:0] cmp_err,
  output logic             lock
);
  localparam int RUN_W = $clog2(GOOD_RUN + 1);
  localparam logic [ERR_W-1:0] UNL_TH  = ERR_W'(UNLOCK_CYC);
  localparam logic [ERR_W-1:0] LCK_TH  = ERR_W'(LOCK_CYC);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(GOOD_RUN);

  logic             lock_q;
  logic [RUN_W-1:0] run_q;
  logic             bad, good;

  assign bad  = leading && (err_cnt >= UNL_TH);
  assign good = cmp_done && (cmp_err <= LCK_TH) && !bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      run_q  <= '0;
    end else if (save) begin
      lock_q <= 1'b1;
      run_q  <= '0;
    end else if (bad) begin
      lock_q <= 1'b0;
      run_q  <= '0;
    end else if (good) begin
      if (run_q + 1'b1 >= RUN_LIM) lock_q <= 1'b1;
      if (run_q != RUN_LIM)        run_q  <= run_q + 1'b1;
    end
  end

  assign lock = save | lock_q;

  // R5: an error at the unlock threshold clears the flag on the next cycle
  p_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !save) |=> !lock_q);

  // R9: power save sets the flag
  p_save_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    save |=> lock_q);

  // R6: the flag only rises on a good comparison or in power save
  p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && !good && !save) |=> !lock_q);
endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage (
  input  logic up,
  input  logic dn,
  input  logic pol_sel,
  input  logic mon_sel,
  input  logic zc_n,
  input  logic save,
  input  logic ref_edge,
  input  logic fb_edge,
  input  logic lock,
  output logic pump_lvl,
  output logic pump_oe,
  output logic ext_a_lvl,
  output logic ext_a_oe,
  output logic ext_b_lvl,
  output logic ext_b_oe,
  output logic mon_out
);
  logic raise, lower;

  // Polarity: raise means drive the tuning voltage up
  assign raise = pol_sel ? up : dn;
  assign lower = pol_sel ? dn : up;

  assign pump_lvl  = raise;
  assign pump_oe   = (raise | lower) & zc_n & ~save;
  assign ext_a_lvl = lower;
  assign ext_a_oe  = ~save;
  assign ext_b_lvl = 1'b0;
  assign ext_b_oe  = raise & ~save;
  assign mon_out   = mon_sel ? (pol_sel ? ref_edge : fb_edge) : lock;
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
  parameter int UNLOCK_CYC = 8,
  parameter int LOCK_CYC   = 16,
  parameter int GOOD_RUN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge,
  input  logic fb_edge,
  input  logic pol_sel,
  input  logic mon_sel,
  input  logic zc_n,
  input  logic ps_n,
  output logic pump_lvl,
  output logic pump_oe,
  output logic ext_a_lvl,
  output logic ext_a_oe,
  output logic ext_b_lvl,
  output logic ext_b_oe,
  output logic lock,
  output logic mon_out
);
  localparam int TH_MAX = (UNLOCK_CYC > LOCK_CYC) ? UNLOCK_CYC : LOCK_CYC;
  localparam int ERR_W  = $clog2(TH_MAX + 1) + 1;

  logic             save;
  logic             up, dn, leading, cmp_done;
  logic [ERR_W-1:0] err_cnt, cmp_err;

  assign save = ~ps_n;

  pfd_core #(.ERR_W(ERR_W)) u_core (
    .clk(clk), .rst_n(rst_n), .hold(save),
    .ref_edge(ref_edge), .fb_edge(fb_edge),
    .up(up), .dn(dn), .leading(leading),
    .err_cnt(err_cnt), .cmp_done(cmp_done), .cmp_err(cmp_err)
  );

  lock_detect #(
    .ERR_W(ERR_W), .UNLOCK_CYC(UNLOCK_CYC),
    .LOCK_CYC(LOCK_CYC), .GOOD_RUN(GOOD_RUN)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .save(save), .leading(leading),
    .err_cnt(err_cnt), .cmp_done(cmp_done), .cmp_err(cmp_err),
    .lock(lock)
  );

  pfd_out_stage u_out (
    .up(up), .dn(dn), .pol_sel(pol_sel), .mon_sel(mon_sel),
    .zc_n(zc_n), .save(save), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .lock(lock),
    .pump_lvl(pump_lvl), .pump_oe(pump_oe),
    .ext_a_lvl(ext_a_lvl), .ext_a_oe(ext_a_oe),
    .ext_b_lvl(ext_b_lvl), .ext_b_oe(ext_b_oe),
    .mon_out(mon_out)
  );

  // R8: forced release keeps the on-chip pump pin undriven
  p_zc_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !zc_n |-> !pump_oe);

  // R9: in power save no pump pin is driven
  p_save_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ps_n |-> (!pump_oe && !ext_a_oe && !ext_b_oe));
endmodule

// File: tb/sim_pfd_lock_top.sv
`timescale 1ns/1ps
module sim_pfd_lock_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_edge = 1'b0, fb_edge = 1'b0, pol_sel = 1'b1, mon_sel = 1'b0;
  logic zc_n = 1'b1, ps_n = 1'b1;
  logic pump_lvl, pump_oe, ext_a_lvl, ext_a_oe, ext_b_lvl, ext_b_oe, lock, mon_out;
  int checks = 0, errs = 0;

  always #2.5 clk = ~clk;

  pfd_lock_top u0 (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .pol_sel(pol_sel), .mon_sel(mon_sel), .zc_n(zc_n), .ps_n(ps_n),
    .pump_lvl(pump_lvl), .pump_oe(pump_oe), .ext_a_lvl(ext_a_lvl), .ext_a_oe(ext_a_oe),
    .ext_b_lvl(ext_b_lvl), .ext_b_oe(ext_b_oe), .lock(lock), .mon_out(mon_out)
  );

  typedef struct packed {
    logic       pol;
    logic       ref_first;
    logic [4:0] gap;
    logic [4:0] hi;
    logic [4:0] lo;
  } vec_t;

  // pol, ref first, gap, expected high cycles, expected low cycles
  localparam vec_t VEC [0:7] = '{
    '{1'b1, 1'b1, 5'd3, 5'd3, 5'd0},
    '{1'b1, 1'b0, 5'd4, 5'd0, 5'd4},
    '{1'b0, 1'b1, 5'd5, 5'd0, 5'd5},
    '{1'b0, 1'b0, 5'd2, 5'd2, 5'd0},
    '{1'b1, 1'b1, 5'd0, 5'd1, 5'd1},
    '{1'b0, 1'b1, 5'd0, 5'd1, 5'd1},
    '{1'b1, 1'b1, 5'd1, 5'd1, 5'd0},
    '{1'b0, 1'b0, 5'd6, 5'd6, 5'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One comparison; counts driven-high and driven-low pump cycles and
  // cycles where the external pins disagree with the pump sense.
  task automatic cmp(input bit rf, input int d, output int hi, output int lo, output int viol);
    hi = 0; lo = 0; viol = 0;
    for (int c = 0; c <= d + 3; c++) begin
      @(negedge clk);
      if (pump_oe && pump_lvl) begin
        hi++;
        if (ext_a_lvl !== 1'b0 || ext_b_oe !== 1'b1) viol++;
      end
      if (pump_oe && !pump_lvl) begin
        lo++;
        if (ext_a_lvl !== 1'b1 || ext_b_oe !== 1'b0) viol++;
      end
      ref_edge = rf ? (c == 0) : (c == d);
      fb_edge  = rf ? (c == d) : (c == 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 100000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int hi, lo, viol;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 R6: reset state is idle and unlocked
    chk(lock == 1'b0, "R6 reset lock", lock, 0);
    chk(pump_oe == 1'b0 && ext_b_oe == 1'b0 && ext_a_lvl == 1'b0, "R4 idle outputs", pump_oe, 0);

    // R1 R2 R3 R4: vector table
    foreach (VEC[i]) begin
      pol_sel = VEC[i].pol;
      cmp(VEC[i].ref_first, int'(VEC[i].gap), hi, lo, viol);
      chk(hi == int'(VEC[i].hi), "R1/R2/R3/R4 high width", hi, int'(VEC[i].hi));
      chk(lo == int'(VEC[i].lo), "R1/R2/R3/R4 low width", lo, int'(VEC[i].lo));
      chk(viol == 0, "R1 R2 R3 external pin sense", viol, 0);
    end

    // R6: lock after exactly three good comparisons
    pol_sel = 1'b1;
    do_reset();
    cmp(1'b1, 2, hi, lo, viol);
    cmp(1'b0, 2, hi, lo, viol);
    chk(lock == 1'b0, "R6 two good", lock, 0);
    cmp(1'b1, 2, hi, lo, viol);
    chk(lock == 1'b1, "R6 three good", lock, 1);
    // R5: boundary at UNLOCK_CYC-1 and UNLOCK_CYC
    cmp(1'b1, 7, hi, lo, viol);
    chk(lock == 1'b1, "R5 error 7 keeps lock", lock, 1);
    cmp(1'b0, 8, hi, lo, viol);
    chk(lock == 1'b0, "R5 error 8 drops lock", lock, 0);

    // R6: a bad comparison restarts the run
    cmp(1'b1, 1, hi, lo, viol);
    cmp(1'b1, 1, hi, lo, viol);
    cmp(1'b1, 9, hi, lo, viol);
    cmp(1'b1, 1, hi, lo, viol);
    cmp(1'b1, 1, hi, lo, viol);
    chk(lock == 1'b0, "R6 run restarted", lock, 0);
    cmp(1'b1, 0, hi, lo, viol);
    chk(lock == 1'b1, "R6 run complete", lock, 1);

    // R5: drop before the closing strobe
    for (int c = 0; c <= 10; c++) begin
      @(negedge clk);
      if (c == 8) chk(lock == 1'b1, "R5 lead 7 cycles", lock, 1);
      if (c == 9) chk(lock == 1'b0, "R5 early drop", lock, 0);
      ref_edge = (c == 0);
      fb_edge  = (c == 10);
    end
    @(negedge clk); fb_edge = 1'b0;
    repeat (2) @(negedge clk);

    // R10: repeated leading strobe ignored
    hi = 0;
    for (int c = 0; c <= 8; c++) begin
      @(negedge clk);
      if (pump_oe && pump_lvl) hi++;
      ref_edge = (c == 0) || (c == 3);
      fb_edge  = (c == 5);
    end
    chk(hi == 5, "R10 second ref ignored", hi, 5);
    // R10: close and restart in one cycle: lead 3 then lead 2
    hi = 0;
    for (int c = 0; c <= 8; c++) begin
      @(negedge clk);
      if (pump_oe && pump_lvl) hi++;
      ref_edge = (c == 0) || (c == 3);
      fb_edge  = (c == 3) || (c == 5);
    end
    chk(hi == 5, "R10 close and restart", hi, 5);

    // R8: forced release during a lead
    for (int c = 0; c <= 5; c++) begin
      @(negedge clk);
      if (c == 2) begin
        zc_n = 1'b0;
        #1;
        chk(pump_oe == 1'b0, "R8 pump released", pump_oe, 0);
        chk(ext_b_oe == 1'b1 && ext_a_oe == 1'b1, "R8 external still driven", ext_b_oe, 1);
        zc_n = 1'b1;
        #1;
        chk(pump_oe == 1'b1, "R8 pump restored", pump_oe, 1);
      end
      ref_edge = (c == 0);
      fb_edge  = (c == 4);
    end

    // R9 with R5 in the same cycle: relock, then save at the eighth lead cycle
    repeat (3) cmp(1'b1, 1, hi, lo, viol);
    for (int c = 0; c <= 11; c++) begin
      @(negedge clk);
      if (c == 9)  chk(lock == 1'b1, "R9 save beats unlock", lock, 1);
      if (c == 11) chk(lock == 1'b1 && pump_oe == 1'b0, "R9 idle after save exit", pump_oe, 0);
      ref_edge = (c == 0);
      fb_edge  = 1'b0;
      if (c == 8)  ps_n = 1'b0;
      if (c == 10) ps_n = 1'b1;
    end

    // R9: save during a lead releases all pins at once
    for (int c = 0; c <= 3; c++) begin
      @(negedge clk);
      if (c == 2) begin
        ps_n = 1'b0;
        #1;
        chk(!pump_oe && !ext_a_oe && !ext_b_oe && lock, "R9 save pins", pump_oe, 0);
      end
      ref_edge = (c == 0);
    end

    // R7: monitor under save, with strobes that must be ignored (R9)
    mon_sel = 1'b1; pol_sel = 1'b1; ref_edge = 1'b1; fb_edge = 1'b0;
    #1 chk(mon_out == 1'b1, "R7 monitor ref", mon_out, 1);
    pol_sel = 1'b0;
    #1 chk(mon_out == 1'b0, "R7 monitor fb low", mon_out, 0);
    fb_edge = 1'b1;
    #1 chk(mon_out == 1'b1, "R7 monitor fb high", mon_out, 1);
    mon_sel = 1'b0;
    #1 chk(mon_out == 1'b1, "R7 monitor lock", mon_out, 1);
    @(negedge clk);
    ref_edge = 1'b0; fb_edge = 1'b0; ps_n = 1'b1;
    @(negedge clk);
    chk(pump_oe == 1'b0 && lock == 1'b1, "R9 strobes ignored in save", pump_oe, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule